// File: doc/BRIEF.md
# Two-Pin Transmit Line Driver Control

This block takes the serial bit stream of a field-bus transmitter and decides, for each of two output pins, whether the pull-up transistor, the pull-down transistor or neither is switched on. Switching neither leaves the pin floating. An 8-bit output control byte selects one of four line modes. It also gives each pin its own polarity and its own enable for each of the two transistors. Four modes exist: plain mirroring of the stream, a clock mode that puts the bit clock on pin 1, a bi-phase mode that steers successive dominant bits to alternate pins, and a test mode that drives a register level to both pins.

Bits arrive as a `bit_valid`/`tx_bit` pair. The block accepts a bit in every cycle where `bit_valid` is high and exerts no back-pressure, so no ready signal exists. Between two accepted bits the last bit is held. Two inputs force the pins. A reset, either the external `rst_n` low or the mode-level `hold_rst` high, floats both pins at once. Sleep drives both pins to their inactive level.

Top module: `can_tx_pin_driver`

## Requirements
- R1: While `rst_n` is low or `hold_rst` is high, all four transistor enables are 0 in the same cycle, so both pins float.
- R2: For neither pin are `pu_on` and `pd_on` ever 1 together.
- R3: Control byte layout: [1:0] mode, [2] pin0 pull-up enable, [3] pin0 pull-down enable, [4] pin0 polarity, [5] pin1 pull-up enable, [6] pin1 pull-down enable, [7] pin1 polarity. With polarity 0 the active level is low and the inactive level is high; polarity 1 swaps them. A pin drives high only if its pull-up is enabled, drives low only if its pull-down is enabled, and otherwise floats.
- R4: Mode 2 (normal): after the clock edge that accepts a bit, both pins show the active level for a dominant bit (`tx_bit`=0) and the inactive level for a recessive bit (`tx_bit`=1).
- R5: Mode 0 (bi-phase): successive accepted dominant bits go alternately to pin 0 and pin 1; only the selected pin shows its active level, the other shows its inactive level.
- R6: In mode 0, an accepted recessive bit leaves both pins at their inactive level and does not advance the alternation.
- R7: On leaving reset, the first dominant bit in mode 0 goes to pin 0.
- R8: Mode 1 (test): `test_level` sampled at a rising edge appears on both pins after that edge; 1 selects the active level.
- R9: Mode 3 (clock): pin 1 shows the active level when `bit_clk` was 1 at the last rising edge; pin 0 behaves as in normal mode.
- R10: While `sleep_en` is high (and no reset), both pins show their inactive level whatever the stream and the mode.
- R11: Cycles with `bit_valid` low change nothing: the held bit and the bi-phase routing stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| hold_rst | input | 1 | Controller reset-mode request, active high |
| sleep_en | input | 1 | Sleep mode, forces inactive levels |
| ctl_byte | input | 8 | Output control byte (layout in R3) |
| bit_valid | input | 1 | Marks a new bit on `tx_bit` |
| tx_bit | input | 1 | Serial bit, 0 dominant, 1 recessive |
| bit_clk | input | 1 | Bit-rate clock for mode 3 |
| test_level | input | 1 | Level for mode 1 |
| pu_on | output | 2 | Pull-up transistor enable per pin |
| pd_on | output | 2 | Pull-down transistor enable per pin |

## Verification
The bench goes after the bi-phase alternation: dominant bits interleaved with recessive bits and with idle cycles, then reset taken in mid-sequence. A design that advanced the alternation on recessive or idle cycles, or that kept the alternation across reset, would send the next dominant bit to the wrong pin. It also walks polarity and transistor-enable combinations so that a swapped polarity or a wrong enable shows up as a high where a float or a low belongs. Finally it mixes sleep and reset with every mode, where a design that gave the mode priority over the forcing inputs would keep driving the line.

// File: rtl/can_txd_pkg.sv
package can_txd_pkg;

  localparam int NPIN = 2;
  localparam int CTL_W = 8;

  typedef enum logic [1:0] {
    OM_BIPHASE = 2'd0,
    OM_TEST    = 2'd1,
    OM_NORMAL  = 2'd2,
    OM_CLOCK   = 2'd3
  } outmode_e;

  typedef struct packed {
    logic pol;
    logic pd_en;
    logic pu_en;
  } pincfg_t;

  typedef struct packed {
    pincfg_t [NPIN-1:0] pin;
    outmode_e           mode;
  } txctl_t;

endpackage

// File: rtl/txd_bit_track.sv
module txd_bit_track
  import can_txd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_rst,
  input  outmode_e        mode,
  input  logic            bit_valid,
  input  logic            tx_bit,
  input  logic            bit_clk,
  input  logic            test_level,
  output logic            cur_dom,
  output logic [NPIN-1:0] bp_act,
  output logic            tst_q,
  output logic            clk_q
);

  logic steer;
  logic dom_in;

  assign dom_in = ~tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_dom <= 1'b0;
      bp_act  <= '0;
      steer   <= 1'b0;
      tst_q   <= 1'b0;
      clk_q   <= 1'b0;
    end else if (hold_rst) begin
      cur_dom <= 1'b0;
      bp_act  <= '0;
      steer   <= 1'b0;
      tst_q   <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      tst_q <= test_level;
      clk_q <= bit_clk;
      if (bit_valid) begin
        cur_dom   <= dom_in;
        bp_act[0] <= dom_in & ~steer;
        bp_act[1] <= dom_in & steer;
        if (dom_in && mode == OM_BIPHASE) steer <= ~steer;
      end
    end
  end

  // R5
  biphase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n || hold_rst)
    (bit_valid && !tx_bit && mode == OM_BIPHASE) |=>
      ($countones(bp_act) == 1 && steer != $past(steer)));

  // R7
  steer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |=> (steer == 1'b0 && bp_act == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || hold_rst)
    !bit_valid |=> ($stable(cur_dom) && $stable(bp_act)));

endmodule

// File: rtl/txd_mode_mux.sv
module txd_mode_mux
  import can_txd_pkg::*;
(
  input  outmode_e        mode,
  input  logic            sleep_en,
  input  logic            cur_dom,
  input  logic [NPIN-1:0] bp_act,
  input  logic            tst_q,
  input  logic            clk_q,
  output logic [NPIN-1:0] act
);

  always_comb begin
    act = '0;
    if (!sleep_en) begin
      unique case (mode)
        OM_BIPHASE: act = bp_act;
        OM_TEST:    act = {NPIN{tst_q}};
        OM_NORMAL:  act = {NPIN{cur_dom}};
        OM_CLOCK:   act = {clk_q, cur_dom};
        default:    act = '0;
      endcase
    end
  end

endmodule

// File: rtl/txd_pin_stage.sv
module txd_pin_stage
  import can_txd_pkg::*;
(
  input  logic    in_rst,
  input  pincfg_t cfg,
  input  logic    act,
  output logic    pu_on,
  output logic    pd_on
);

  logic want_high;

  // active level is low for pol=0, high for pol=1
  assign want_high = act ? cfg.pol : ~cfg.pol;
  assign pu_on = ~in_rst & cfg.pu_en & want_high;
  assign pd_on = ~in_rst & cfg.pd_en & ~want_high;

endmodule

// File: rtl/can_tx_pin_driver.sv
module can_tx_pin_driver
  import can_txd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_rst,
  input  logic             sleep_en,
  input  logic [CTL_W-1:0] ctl_byte,
  input  logic             bit_valid,
  input  logic             tx_bit,
  input  logic             bit_clk,
  input  logic             test_level,
  output logic [NPIN-1:0]  pu_on,
  output logic [NPIN-1:0]  pd_on
);

  txctl_t          ctl;
  logic            in_rst;
  logic            cur_dom;
  logic [NPIN-1:0] bp_act;
  logic            tst_q;
  logic            clk_q;
  logic [NPIN-1:0] act;

  assign ctl    = txctl_t'(ctl_byte);
  assign in_rst = ~rst_n | hold_rst;

  txd_bit_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_rst   (hold_rst),
    .mode       (ctl.mode),
    .bit_valid  (bit_valid),
    .tx_bit     (tx_bit),
    .bit_clk    (bit_clk),
    .test_level (test_level),
    .cur_dom    (cur_dom),
    .bp_act     (bp_act),
    .tst_q      (tst_q),
    .clk_q      (clk_q)
  );

  txd_mode_mux u_mux (
    .mode     (ctl.mode),
    .sleep_en (sleep_en),
    .cur_dom  (cur_dom),
    .bp_act   (bp_act),
    .tst_q    (tst_q),
    .clk_q    (clk_q),
    .act      (act)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    txd_pin_stage u_pin (
      .in_rst (in_rst),
      .cfg    (ctl.pin[p]),
      .act    (act[p]),
      .pu_on  (pu_on[p]),
      .pd_on  (pd_on[p])
    );
  end

  // R1
  always_comb begin
    if (in_rst) reset_float_chk: assert (pu_on == '0 && pd_on == '0);
  end

  // R10
  sleep_idle_chk: assert property (@(posedge clk) disable iff (in_rst)
    sleep_en |-> (act == '0));

endmodule

// File: tb/tb_can_tx_pin_driver.sv
module tb_can_tx_pin_driver;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_rst = 1'b0;
  logic       sleep_en = 1'b0;
  logic [7:0] ctl_byte = 8'h00;
  logic       bit_valid = 1'b0;
  logic       tx_bit = 1'b1;
  logic       bit_clk = 1'b0;
  logic       test_level = 1'b0;
  logic [1:0] pu_on, pd_on;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_tx_pin_driver dut (
    .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .sleep_en(sleep_en),
    .ctl_byte(ctl_byte), .bit_valid(bit_valid), .tx_bit(tx_bit),
    .bit_clk(bit_clk), .test_level(test_level), .pu_on(pu_on), .pd_on(pd_on)
  );

  // behavioural reference state
  bit m_dom, m_next_pin1, m_bp0, m_bp1, m_tst, m_clk;

  function automatic string mode_tag();
    if (!rst_n || hold_rst) return "R1";
    if (sleep_en) return "R10";
    case (ctl_byte[1:0])
      2'd0: return "R5";
      2'd1: return "R8";
      2'd2: return "R4";
      default: return "R9";
    endcase
  endfunction

  function automatic bit model_act(int p);
    if (sleep_en) return 1'b0;
    case (ctl_byte[1:0])
      2'd0: return (p == 0) ? m_bp0 : m_bp1;
      2'd1: return m_tst;
      2'd2: return m_dom;
      default: return (p == 1) ? m_clk : m_dom;
    endcase
  endfunction

  task automatic model_expect(output logic [1:0] epu, output logic [1:0] epd);
    for (int p = 0; p < 2; p++) begin
      bit pu_en = ctl_byte[2 + 3*p];
      bit pd_en = ctl_byte[3 + 3*p];
      bit pol   = ctl_byte[4 + 3*p];
      bit hi    = model_act(p) ? pol : !pol;
      if (!rst_n || hold_rst) begin
        epu[p] = 1'b0; epd[p] = 1'b0;
      end else begin
        epu[p] = pu_en && hi;
        epd[p] = pd_en && !hi;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n || hold_rst) begin
      m_dom = 0; m_next_pin1 = 0; m_bp0 = 0; m_bp1 = 0; m_tst = 0; m_clk = 0;
    end else begin
      if (bit_valid) begin
        m_dom = !tx_bit;
        m_bp0 = !tx_bit && !m_next_pin1;
        m_bp1 = !tx_bit && m_next_pin1;
        if (!tx_bit && ctl_byte[1:0] == 2'd0) m_next_pin1 = !m_next_pin1;
      end
      m_tst = test_level;
      m_clk = bit_clk;
    end
    #1;
    if (!done) begin
      logic [1:0] epu, epd;
      model_expect(epu, epd);
      checks++;
      if (pu_on !== epu || pd_on !== epd) begin
        errors++;
        $display("FAIL %s/R3 cycle compare: pu=%b pd=%b expected pu=%b pd=%b",
                 mode_tag(), pu_on, pd_on, epu, epd);
      end
      checks++;
      if ((pu_on & pd_on) != 2'b00) begin
        errors++;
        $display("FAIL R2 both transistors on: pu=%b pd=%b expected no overlap", pu_on, pd_on);
      end
    end
  end

  task automatic chk(string tag, logic [1:0] epu, logic [1:0] epd);
    checks++;
    if (pu_on !== epu || pd_on !== epd) begin
      errors++;
      $display("FAIL %s: pu=%b pd=%b expected pu=%b pd=%b", tag, pu_on, pd_on, epu, epd);
    end
  endtask

  task automatic send(bit b);
    @(negedge clk); bit_valid = 1'b1; tx_bit = b;
    @(negedge clk); bit_valid = 1'b0; tx_bit = !b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(60000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // all enables on, polarity 0 (active low), bi-phase
    ctl_byte = 8'b0_1_1_0_1_1_00;
    idle(3);
    chk("R1 external reset floats", 2'b00, 2'b00);
    rst_n = 1'b1;
    idle(2);
    chk("R6 idle recessive both high", 2'b11, 2'b00);

    send(0); chk("R5 first dominant on pin0", 2'b10, 2'b01);
    send(1); chk("R6 recessive both inactive", 2'b11, 2'b00);
    idle(3); chk("R11 idle keeps state", 2'b11, 2'b00);
    send(0); chk("R5 second dominant on pin1", 2'b01, 2'b10);
    send(0); chk("R5 third dominant on pin0", 2'b10, 2'b01);

    @(negedge clk); hold_rst = 1'b1;
    @(negedge clk); chk("R1 reset request floats", 2'b00, 2'b00);
    hold_rst = 1'b0;
    send(0); chk("R7 restart on pin0", 2'b10, 2'b01);

    // normal mode, pin1 polarity 1, pin0 pull-down only
    ctl_byte = 8'b1_1_1_0_1_0_10;
    send(0); chk("R4 dominant normal", 2'b10, 2'b01);
    send(1); chk("R3 recessive pin0 float", 2'b00, 2'b10);
    @(negedge clk); bit_valid = 1'b0; tx_bit = 1'b0;
    idle(2); chk("R11 no valid no change", 2'b00, 2'b10);

    // test mode, polarity 0 both pins
    ctl_byte = 8'b0_1_1_0_1_1_01;
    @(negedge clk); test_level = 1'b1;
    @(negedge clk); chk("R8 test level active", 2'b00, 2'b11);
    test_level = 1'b0;
    @(negedge clk); chk("R8 test level inactive", 2'b11, 2'b00);

    // clock mode
    ctl_byte = 8'b0_1_1_0_1_1_11;
    @(negedge clk); bit_clk = 1'b1;
    @(negedge clk); chk("R9 clock on pin1", 2'b01, 2'b10);
    bit_clk = 1'b0;

    // sleep
    ctl_byte = 8'b0_1_1_0_1_1_10;
    send(0);
    sleep_en = 1'b1;
    @(negedge clk); chk("R10 sleep inactive", 2'b11, 2'b00);
    sleep_en = 1'b0;

    // random mix, compared every clock against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ctl_byte   = ((i % 97) == 0) ? 8'($urandom) : ctl_byte;
      bit_valid  = ($urandom % 3) == 0;
      tx_bit     = $urandom % 2;
      bit_clk    = $urandom % 2;
      test_level = $urandom % 2;
      sleep_en   = ($urandom % 23) == 0;
      hold_rst   = ($urandom % 41) == 0;
      rst_n      = ($urandom % 211) != 0;
    end
    @(negedge clk);
    rst_n = 1'b1; hold_rst = 1'b0; bit_valid = 1'b0;
    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule